// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block moves 16-bit words between a register-side command port and a byte-wide, single-port synchronous memory through a descending 16-bit stack pointer that it owns. One command starts one short fixed sequence of memory steps. The commands are: push a register pair, pop a register pair, push a return address for a subroutine call, pop a return address, swap a register pair with the word on top of the stack, and load the stack pointer from a register pair. When the last memory step of a sequence has finished, the block raises `done` for one cycle and presents the 16-bit result.

In a word, the high byte always sits one address above the low byte. A push writes the high byte first and moves downward. A pop reads the low byte first and moves upward. When a pair holds accumulator and flags, the accumulator is the high byte and the flag byte is the low byte. The memory returns read data one cycle after it is given the address, so each read step is followed by a cycle in which the data is captured. Instruction decode, arithmetic and the program counter itself are outside the block: the caller supplies the return address for a call and takes the popped address for a return.

Top module: `stack_xfer_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sp_value` equals the parameter `SP_INIT`, `cmd_ready` is 1, and both `done` and `mem_we` are 0.
- R2: Push (`cmd_op`=1) and call (`cmd_op`=3) write `cmd_arg[15:8]` at SP-1 and then `cmd_arg[7:0]` at SP-2, in that order. SP ends 2 lower. `result` is the new SP. `done` rises 3 cycles after the cycle in which the command was accepted.
- R3: Pop (`cmd_op`=2) and return (`cmd_op`=4) read the low byte at SP and the high byte at SP+1. SP ends 2 higher. `result` is {high, low}. `done` rises 4 cycles after acceptance.
- R4: Swap (`cmd_op`=5) writes `cmd_arg[7:0]` at SP and `cmd_arg[15:8]` at SP+1. `result` is the word held there before the swap. SP does not change at any point. `done` rises 5 cycles after acceptance.
- R5: Load-pointer (`cmd_op`=6) sets SP to `cmd_arg`, with `cmd_arg[15:8]` as the upper address byte. It performs no memory write, `result` equals `cmd_arg`, and `done` rises 1 cycle after acceptance.
- R6: SP arithmetic wraps modulo 2^16: decrementing 0x0000 gives 0xFFFF and incrementing 0xFFFF gives 0x0000. Apart from a load, SP moves by exactly one per cycle when it moves.
- R7: A command is accepted only when `cmd_valid` is high while `cmd_ready` is high. `cmd_ready` is low from the cycle after acceptance through the `done` cycle. Commands presented while `cmd_ready` is low have no effect, and codes 0 and 7 are never accepted.
- R8: `done` is high for exactly one cycle per accepted command.
- R9: `mem_we` is high only during the write steps of a command: twice for push, call and swap, never for pop, return and load-pointer, and never while `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (1 push, 2 pop, 3 call, 4 return, 5 swap, 6 load pointer) |
| cmd_arg | input | 16 | Register pair, return address or new pointer |
| cmd_ready | output | 1 | Block is idle and can take a command |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after its address |
| result | output | 16 | Result word, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |
| sp_value | output | 16 | Current stack pointer |

## Verification
The bench builds the block with `SP_INIT` = 0x0000. With that value, the very first push must wrap the pointer below zero, so it writes its high byte at 0xFFFF and its low byte at 0xFFFE. Later in the run, a load of 0xFFFF followed by a pop brings the upward wrap within reach: the low byte is read at 0xFFFF and the high byte at 0x0000. The swap and the pop that follow it confirm that the swap changed memory without moving the pointer.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PW = 2 * DW;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PUSH = 3'd1, OP_POP = 3'd2, OP_CALL = 3'd3,
    OP_RET  = 3'd4, OP_SWAP = 3'd5, OP_LDSP = 3'd6, OP_RSVD = 3'd7
  } stk_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PU_HI, ST_PU_LO, ST_PO_LO, ST_PO_HI, ST_PO_END,
    ST_SW_RLO, ST_SW_WLO, ST_SW_RHI, ST_SW_WHI
  } stk_state_e;

  typedef enum logic [1:0] {SPC_HOLD, SPC_DEC, SPC_INC, SPC_LOAD} sp_cmd_e;
  typedef enum logic [1:0] {AD_SP, AD_SP_M1, AD_SP_P1} addr_sel_e;

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return AW'(p - AW'(1));
  endfunction

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return AW'(p + AW'(1));
  endfunction

  function automatic logic op_legal(input logic [2:0] op);
    return (op != OP_NONE) && (op != OP_RSVD);
  endfunction

  function automatic logic op_gives_sp(input logic [2:0] op);
    return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_LDSP);
  endfunction
endpackage

// File: rtl/stk_pointer.sv
module stk_pointer
  import stk_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_cmd_e       sp_cmd,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_INIT;
    end else begin
      case (sp_cmd)
        SPC_DEC:  sp_q <= ptr_dec(sp_q);
        SPC_INC:  sp_q <= ptr_inc(sp_q);
        SPC_LOAD: sp_q <= load_val;
        default:  sp_q <= sp_q;
      endcase
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  input  logic [2:0] cmd_op,
  output logic      ready,
  output logic      accept,
  output sp_cmd_e   sp_cmd,
  output addr_sel_e addr_sel,
  output logic      we,
  output logic      wsel_hi,
  output logic      cap_lo,
  output logic      cap_hi,
  output logic      res_from_sp,
  output logic      swap_busy,
  output logic      done
);
  stk_state_e state_q, state_d;
  logic       fin;

  assign ready     = (state_q == ST_IDLE) && !done;
  assign accept    = cmd_valid && ready && op_legal(cmd_op);
  assign swap_busy = (state_q == ST_SW_RLO) || (state_q == ST_SW_WLO) ||
                     (state_q == ST_SW_RHI) || (state_q == ST_SW_WHI);

  always_comb begin
    state_d  = state_q;
    sp_cmd   = SPC_HOLD;
    addr_sel = AD_SP;
    we       = 1'b0;
    wsel_hi  = 1'b0;
    cap_lo   = 1'b0;
    cap_hi   = 1'b0;
    fin      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          case (cmd_op)
            OP_PUSH, OP_CALL: state_d = ST_PU_HI;
            OP_POP,  OP_RET:  state_d = ST_PO_LO;
            OP_SWAP:          state_d = ST_SW_RLO;
            default: begin
              sp_cmd = SPC_LOAD;
              fin    = 1'b1;
            end
          endcase
        end
      end
      ST_PU_HI: begin
        sp_cmd = SPC_DEC; addr_sel = AD_SP_M1; we = 1'b1; wsel_hi = 1'b1;
        state_d = ST_PU_LO;
      end
      ST_PU_LO: begin
        sp_cmd = SPC_DEC; addr_sel = AD_SP_M1; we = 1'b1;
        fin = 1'b1; state_d = ST_IDLE;
      end
      ST_PO_LO: begin
        sp_cmd = SPC_INC; state_d = ST_PO_HI;
      end
      ST_PO_HI: begin
        sp_cmd = SPC_INC; cap_lo = 1'b1; state_d = ST_PO_END;
      end
      ST_PO_END: begin
        cap_hi = 1'b1; fin = 1'b1; state_d = ST_IDLE;
      end
      ST_SW_RLO: state_d = ST_SW_WLO;
      ST_SW_WLO: begin
        we = 1'b1; cap_lo = 1'b1; state_d = ST_SW_RHI;
      end
      ST_SW_RHI: begin
        addr_sel = AD_SP_P1; state_d = ST_SW_WHI;
      end
      ST_SW_WHI: begin
        addr_sel = AD_SP_P1; we = 1'b1; wsel_hi = 1'b1; cap_hi = 1'b1;
        fin = 1'b1; state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      done        <= 1'b0;
      res_from_sp <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= fin;
      if (accept) res_from_sp <= op_gives_sp(cmd_op);
    end
  end
endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [PW-1:0] cmd_arg,
  input  logic [AW-1:0] sp,
  input  addr_sel_e     addr_sel,
  input  logic          wsel_hi,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic          res_from_sp,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [PW-1:0] result
);
  logic [PW-1:0] opnd_q;
  logic [DW-1:0] lo_q, hi_q;

  always_comb begin
    case (addr_sel)
      AD_SP_M1: mem_addr = ptr_dec(sp);
      AD_SP_P1: mem_addr = ptr_inc(sp);
      default:  mem_addr = sp;
    endcase
  end

  assign mem_wdata = wsel_hi ? opnd_q[PW-1:DW] : opnd_q[DW-1:0];
  assign result    = res_from_sp ? PW'(sp) : {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (accept) opnd_q <= cmd_arg;
      if (cap_lo) lo_q <= mem_rdata;
      if (cap_hi) hi_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/stack_xfer_engine.sv
module stack_xfer_engine
  import stk_pkg::*;
#(
  parameter logic [15:0] SP_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] cmd_arg,
  output logic        cmd_ready,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] result,
  output logic        done,
  output logic [15:0] sp_value
);
  sp_cmd_e   sp_cmd;
  addr_sel_e addr_sel;
  logic      wsel_hi, cap_lo, cap_hi, res_from_sp;
  logic      ev_accept, ev_swap_busy, ev_sp_load;

  assign ev_sp_load = (sp_cmd == SPC_LOAD);

  stk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .ready(cmd_ready), .accept(ev_accept), .sp_cmd(sp_cmd),
    .addr_sel(addr_sel), .we(mem_we), .wsel_hi(wsel_hi), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .res_from_sp(res_from_sp), .swap_busy(ev_swap_busy),
    .done(done)
  );

  stk_pointer #(.SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sp_cmd(sp_cmd), .load_val(cmd_arg),
    .sp_q(sp_value)
  );

  stk_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .accept(ev_accept), .cmd_arg(cmd_arg),
    .sp(sp_value), .addr_sel(addr_sel), .wsel_hi(wsel_hi), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .res_from_sp(res_from_sp), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .result(result)
  );
endmodule

// File: rtl/stk_xfer_checker.sv
module stk_xfer_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        mem_we,
  input logic        done,
  input logic [15:0] sp_value,
  input logic        ev_accept,
  input logic        ev_swap_busy,
  input logic        ev_sp_load
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_we); // R9

  AST_SWAP_KEEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap_busy |=> (sp_value == $past(sp_value))); // R4

  AST_SP_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((sp_value != $past(sp_value)) && !$past(ev_sp_load)) |->
      ((sp_value == 16'($past(sp_value) + 16'd1)) ||
       (sp_value == 16'($past(sp_value) - 16'd1)))); // R6

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> !ev_accept); // R7

  AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sp_load |=> done); // R5
endmodule

bind stack_xfer_engine stk_xfer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .mem_we(mem_we),
  .done(done), .sp_value(sp_value), .ev_accept(ev_accept),
  .ev_swap_busy(ev_swap_busy), .ev_sp_load(ev_sp_load)
);

// File: tb/stack_xfer_engine_bench.sv
module stack_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_arg = 16'h0000;
  logic        cmd_ready, mem_we, done;
  logic [15:0] mem_addr, result, sp_value;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;

  logic [7:0]  ram     [logic [15:0]];
  logic [7:0]  ref_mem [logic [15:0]];
  logic [15:0] ref_sp = 16'h0000;
  int          we_count = 0;

  always #5 clk = ~clk;

  stack_xfer_engine #(.SP_INIT(16'h0000)) u_stack_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .result(result), .done(done), .sp_value(sp_value)
  );

  always @(posedge clk) begin
    logic [7:0] v;
    v = ram.exists(mem_addr) ? ram[mem_addr] : 8'h00;
    if (mem_we) begin
      ram[mem_addr] = mem_wdata;
      we_count++;
    end
    mem_rdata <= v;
  end

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [15:0] arg,
                        input string tag, input bit noise);
    int          lat;
    int          exp_we;
    logic [15:0] exp_res;
    logic [15:0] a;
    logic [7:0]  lo, hi;
    case (op)
      3'd1, 3'd3: begin
        ref_sp = ref_sp - 16'd1; ref_mem[ref_sp] = arg[15:8];
        ref_sp = ref_sp - 16'd1; ref_mem[ref_sp] = arg[7:0];
        exp_res = ref_sp; lat = 3; exp_we = 2;
      end
      3'd2, 3'd4: begin
        lo = ref_rd(ref_sp); ref_sp = ref_sp + 16'd1;
        hi = ref_rd(ref_sp); ref_sp = ref_sp + 16'd1;
        exp_res = {hi, lo}; lat = 4; exp_we = 0;
      end
      3'd5: begin
        a = ref_sp;
        exp_res = {ref_rd(a + 16'd1), ref_rd(a)};
        ref_mem[a] = arg[7:0];
        ref_mem[a + 16'd1] = arg[15:8];
        lat = 5; exp_we = 2;
      end
      default: begin
        ref_sp = arg; exp_res = arg; lat = 1; exp_we = 0;
      end
    endcase
    while (!cmd_ready) @(negedge clk);
    we_count = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    if (noise) begin
      cmd_op = 3'd6; cmd_arg = 16'h1234;   // R7: presented while busy
    end else begin
      cmd_valid = 1'b0;
    end
    for (int c = 1; c <= lat; c++) begin
      chk(done == (c == lat), "R8", "done timing", 32'(done), 32'(c == lat));
      if (c == lat) begin
        cmd_valid = 1'b0;
        chk(result == exp_res, tag, "result", 32'(result), 32'(exp_res));
        chk(sp_value == ref_sp, tag, "stack pointer", 32'(sp_value), 32'(ref_sp));
        chk(we_count == exp_we, "R9", "write count", 32'(we_count), 32'(exp_we));
        foreach (ref_mem[k]) begin
          logic [7:0] got;
          got = ram.exists(k) ? ram[k] : 8'h00;
          chk(got == ref_mem[k], tag, "memory byte", {k, 8'h00, got}, {k, 8'h00, ref_mem[k]});
        end
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", "done after pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sp_value == 16'h0000, "R1", "reset pointer", 32'(sp_value), 32'h0);
    chk(cmd_ready && !done && !mem_we, "R1", "reset outputs",
        {29'd0, cmd_ready, done, mem_we}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_value == 16'h0000 && cmd_ready, "R1", "first cycle after reset",
        {sp_value, 15'd0, cmd_ready}, 32'h1);

    do_cmd(3'd1, 16'hA1B2, "R6", 1'b0);   // R2 push wrapping below zero
    do_cmd(3'd3, 16'h1234, "R2", 1'b0);   // call
    do_cmd(3'd4, 16'h0000, "R3", 1'b0);   // return gives 0x1234
    do_cmd(3'd5, 16'h5566, "R4", 1'b0);   // swap top with A1B2
    do_cmd(3'd2, 16'h0000, "R3", 1'b0);   // pop gives 5566
    do_cmd(3'd6, 16'h8000, "R5", 1'b0);
    do_cmd(3'd1, 16'h7F02, "R7", 1'b1);   // accumulator/flags push, busy noise
    do_cmd(3'd5, 16'hC3D4, "R4", 1'b1);
    do_cmd(3'd2, 16'h0000, "R3", 1'b0);   // pops C3D4
    do_cmd(3'd6, 16'hFFFF, "R5", 1'b0);
    do_cmd(3'd2, 16'h0000, "R6", 1'b0);   // pop wrapping above 0xFFFF

    // R7: codes 0 and 7 ignored
    for (int i = 0; i < 4; i++) begin
      cmd_valid = 1'b1; cmd_op = (i % 2 == 0) ? 3'd7 : 3'd0; cmd_arg = 16'h4242;
      @(negedge clk);
      chk(!done && cmd_ready && sp_value == ref_sp && !mem_we, "R7",
          "illegal code ignored", {done, cmd_ready, mem_we, 13'd0, sp_value},
          {3'b010, 13'd0, ref_sp});
    end
    cmd_valid = 1'b0;
    do_cmd(3'd2, 16'h0000, "R3", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule